// File: doc/BRIEF.md
# BCD Fractional-N Divide Ratio Accumulator

This block sits between a frequency programmer and the divide-by-N counter of a phase-locked synthesizer. It takes a frequency word written as seven binary-coded-decimal digits. The upper three digits give the integer divide ratio in units of the 100 kHz reference. The lower four digits give the fractional part, with a resolution of 10 Hz. On every reference tick the block chooses the divide ratio for the next reference period. Over time, the ratios it chooses average to the exact programmed value.

A four-digit decimal accumulator adds the fractional digits on each tick, with decimal carry between digits. When the most significant fractional digit carries out, the ratio for that period rises from N to N+1. The accumulator contents after the addition leave the block as a residue word, which a downstream phase-error correction circuit uses to cancel the phase step caused by the extra count. A new frequency word is held in a shadow register and takes effect only at the next tick, which is the frame boundary. That tick also clears the accumulator.

Top module: `bcd_frac_accum`

## Requirements
- R1: While rst_ni is low, and after its release before any tick, ratio_o, carry_o and residue_o are all zero.
- R2: freq_i holds decimal digit k in bits [4k+3:4k]. Digits 6..4 form the integer ratio N in hundreds of kHz, and digits 3..0 form the fraction F in units of 10 Hz. For example, 43.501 MHz is written 0x4350100.
- R3: On a tick that applies no new word, residue_o becomes (residue_o + F) mod 10000, computed in decimal and presented in the same BCD layout as the fraction.
- R4: On such a tick, carry_o is 1 for the coming period exactly when the decimal addition carried out of the top fractional digit.
- R5: On such a tick, ratio_o (binary) becomes N + carry_o.
- R6: While tick_i is low, ratio_o, carry_o and residue_o do not change.
- R7: A word strobed in with load_i takes effect at the first tick after the strobe. That tick sets residue_o to 0, carry_o to 0 and ratio_o to the new N. A strobe without a tick leaves the outputs unchanged.
- R8: With 43.501 MHz programmed, ratio_o is 436 on exactly one tick in every 100 accumulating ticks and 435 on the others. The top two residue digits advance by 1 modulo 100 on each tick.
- R9: Every 4-bit digit of residue_o is always in the range 0 to 9.
- R10: A load strobe that arrives on the same cycle as a tick is not applied at that tick. The tick uses the word that was already pending, or accumulates if none was pending, and the new word is applied at the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Reference period boundary, one clock wide |
| load_i | input | 1 | Strobe to capture freq_i |
| freq_i | input | 28 | Seven-digit BCD frequency word |
| ratio_o | output | 10 | Binary divide ratio for the current reference period |
| carry_o | output | 1 | Set when the current period uses N+1 |
| residue_o | output | 16 | Four-digit BCD accumulator contents after the addition |

## Verification
A corrupted accumulator digit shows up on residue_o at the very next tick, as a value that is off the expected decimal sequence or is not valid BCD. Within at most 10000/F ticks it also shows up as a carry that comes too early or too late, and so as a 436 in the wrong place. An error in the shadow or pending logic shows up as a ratio that changes one tick too soon or too late after a load. The reference model is compared on every clock, so a fault is reported in the first cycle after the tick at which it occurs.

// File: rtl/bcd_frac_pkg.sv
package bcd_frac_pkg;
  localparam int unsigned DIGIT_W = 4;
  typedef logic [DIGIT_W-1:0] bcd_digit_t;
endpackage

// File: rtl/bcd_adder.sv
module bcd_adder
  import bcd_frac_pkg::*;
#(
  parameter int unsigned DIGITS = 4,
  localparam int unsigned W = DIGITS * DIGIT_W
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o,
  output logic         carry_o
);
  logic [DIGITS:0] c;
  assign c[0] = 1'b0;

  for (genvar g = 0; g < DIGITS; g++) begin : g_dig
    logic [DIGIT_W:0] raw;
    assign raw = {1'b0, a_i[g*DIGIT_W +: DIGIT_W]} + {1'b0, b_i[g*DIGIT_W +: DIGIT_W]}
               + {{DIGIT_W{1'b0}}, c[g]};
    assign c[g+1] = raw > 5'd9;
    assign sum_o[g*DIGIT_W +: DIGIT_W] = c[g+1] ? DIGIT_W'(raw - 5'd10) : raw[DIGIT_W-1:0];
  end

  assign carry_o = c[DIGITS];
endmodule

// File: rtl/bcd_to_bin.sv
module bcd_to_bin
  import bcd_frac_pkg::*;
#(
  parameter int unsigned DIGITS = 3,
  parameter int unsigned OUT_W  = 10,
  localparam int unsigned W = DIGITS * DIGIT_W
) (
  input  logic [W-1:0]     bcd_i,
  output logic [OUT_W-1:0] bin_o
);
  always_comb begin
    bin_o = '0;
    for (int i = DIGITS - 1; i >= 0; i--) begin
      bin_o = bin_o * OUT_W'(10) + OUT_W'(bcd_i[i*DIGIT_W +: DIGIT_W]);
    end
  end
endmodule

// File: rtl/bcd_frac_accum.sv
module bcd_frac_accum
  import bcd_frac_pkg::*;
#(
  parameter int unsigned INT_DIGITS  = 3,
  parameter int unsigned FRAC_DIGITS = 4,
  localparam int unsigned INT_W   = INT_DIGITS * DIGIT_W,
  localparam int unsigned FRAC_W  = FRAC_DIGITS * DIGIT_W,
  localparam int unsigned WORD_W  = INT_W + FRAC_W,
  localparam int unsigned RATIO_W = $clog2(10**INT_DIGITS + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               load_i,
  input  logic [WORD_W-1:0]  freq_i,
  output logic [RATIO_W-1:0] ratio_o,
  output logic               carry_o,
  output logic [FRAC_W-1:0]  residue_o
);
  logic [WORD_W-1:0]  shadow_q, word_q;
  logic               pend_q;
  logic [FRAC_W-1:0]  sum;
  logic               sum_carry;
  logic [RATIO_W-1:0] n_act, n_new;

  bcd_adder #(.DIGITS(FRAC_DIGITS)) i_add (
    .a_i    (residue_o),
    .b_i    (word_q[FRAC_W-1:0]),
    .sum_o  (sum),
    .carry_o(sum_carry)
  );

  bcd_to_bin #(.DIGITS(INT_DIGITS), .OUT_W(RATIO_W)) i_n_act (
    .bcd_i(word_q[WORD_W-1:FRAC_W]),
    .bin_o(n_act)
  );

  bcd_to_bin #(.DIGITS(INT_DIGITS), .OUT_W(RATIO_W)) i_n_new (
    .bcd_i(shadow_q[WORD_W-1:FRAC_W]),
    .bin_o(n_new)
  );

  // load lands in shadow; applied at the next frame boundary (tick)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q  <= '0;
      word_q    <= '0;
      pend_q    <= 1'b0;
      ratio_o   <= '0;
      carry_o   <= 1'b0;
      residue_o <= '0;
    end else begin
      if (load_i) shadow_q <= freq_i;
      pend_q <= load_i | (pend_q & ~tick_i);
      if (tick_i) begin
        if (pend_q) begin
          word_q    <= shadow_q;
          residue_o <= '0;
          carry_o   <= 1'b0;
          ratio_o   <= n_new;
        end else begin
          residue_o <= sum;
          carry_o   <= sum_carry;
          ratio_o   <= n_act + RATIO_W'(sum_carry);
        end
      end
    end
  end

  // R6
  hold_between_ticks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(residue_o) && $stable(ratio_o) && $stable(carry_o));

  // R4
  carry_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !pend_q |=> carry_o == (residue_o < $past(residue_o)));

  // R5
  ratio_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !pend_q |=> ratio_o == $past(n_act) + RATIO_W'(carry_o));

  // R7
  apply_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && pend_q |=> residue_o == '0 && !carry_o && ratio_o == $past(n_new));

  // R9
  for (genvar g = 0; g < FRAC_DIGITS; g++) begin : g_chk
    digit_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      residue_o[g*DIGIT_W +: DIGIT_W] <= 4'd9);
  end
endmodule

// File: tb/test_bcd_frac_accum.sv
module test_bcd_frac_accum;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic        load_i = 1'b0;
  logic [27:0] freq_i = '0;
  logic [9:0]  ratio_o;
  logic        carry_o;
  logic [15:0] residue_o;

  int checks = 0;
  int errors = 0;

  // model state (plain integers)
  int m_act = 0, m_shadow = 0, m_acc = 0, m_ratio = 0, m_carry = 0;
  bit m_pend = 0;

  always #2.5 clk_i = ~clk_i;

  bcd_frac_accum i_bcd_frac_accum (
    .clk_i, .rst_ni, .tick_i, .load_i, .freq_i, .ratio_o, .carry_o, .residue_o
  );

  function automatic logic [27:0] to_bcd(int v);
    logic [27:0] r = '0;
    for (int i = 0; i < 7; i++) begin
      r[4*i +: 4] = 4'(v % 10);
      v = v / 10;
    end
    return r;
  endfunction

  function automatic int from_bcd16(logic [15:0] b);
    int r = 0;
    for (int i = 3; i >= 0; i--) r = r * 10 + int'(b[4*i +: 4]);
    return r;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic compare(string req);
    bit dig_ok = 1;
    for (int i = 0; i < 4; i++) if (residue_o[4*i +: 4] > 4'd9) dig_ok = 0;
    check(dig_ok, "R9 digit range", int'(residue_o), 0);
    check(int'(ratio_o) == m_ratio, {req, " ratio"}, int'(ratio_o), m_ratio);
    check(int'(carry_o) == m_carry, {req, " carry"}, int'(carry_o), m_carry);
    check(from_bcd16(residue_o) == m_acc, {req, " residue"}, from_bcd16(residue_o), m_acc);
  endtask

  // drive one cycle at negedge, advance model, compare at next negedge
  task automatic step(bit tk, bit ld, int word);
    string req;
    tick_i = tk;
    load_i = ld;
    freq_i = to_bcd(word);
    if (tk && m_pend) begin
      req = "R7 R10 apply";
      m_act = m_shadow; m_acc = 0; m_carry = 0; m_ratio = m_shadow / 10000;
    end else if (tk) begin
      int s = m_acc + m_act % 10000;
      req = "R3 R4 R5 accumulate";
      m_carry = (s >= 10000) ? 1 : 0;
      m_acc = s % 10000;
      m_ratio = m_act / 10000 + m_carry;
    end else begin
      req = ld ? "R7 load-no-tick" : "R6 hold";
    end
    m_pend = ld | (m_pend & !tk);
    if (ld) m_shadow = word;
    @(posedge clk_i);
    @(negedge clk_i);
    tick_i = 0; load_i = 0;
    compare(req);
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int cnt436, ticks, prev_hi;
    repeat (3) @(negedge clk_i);
    compare("R1 in reset");
    rst_ni = 1;
    @(negedge clk_i);
    compare("R1 after reset");
    step(0, 0, 0);

    // R2 R8: 43.501 MHz
    step(0, 1, 4350100);
    step(0, 0, 0);
    step(1, 0, 0);
    prev_hi = from_bcd16(residue_o) / 100;
    for (int blk = 0; blk < 3; blk++) begin
      cnt436 = 0;
      ticks = 0;
      while (ticks < 100) begin
        step(1, 0, 0);
        ticks++;
        if (ratio_o == 10'd436) cnt436++;
        check(ratio_o == 10'd435 || ratio_o == 10'd436, "R8 ratio set", int'(ratio_o), 435);
        check(from_bcd16(residue_o) / 100 == (prev_hi + 1) % 100, "R8 residue step",
              from_bcd16(residue_o) / 100, (prev_hi + 1) % 100);
        prev_hi = from_bcd16(residue_o) / 100;
        if (ticks % 7 == 0) step(0, 0, 0);
      end
      check(cnt436 == 1, "R8 one 436 per 100", cnt436, 1);
    end

    // R7: load without tick leaves outputs
    step(0, 1, 5999999);
    step(0, 0, 0);
    step(1, 0, 0);
    for (int i = 0; i < 30; i++) step(1, 0, 0);

    // R10: load on a tick with nothing pending
    step(1, 1, 4000000);
    step(1, 0, 0);
    for (int i = 0; i < 10; i++) step(1, 0, 0);

    // R10: load on a tick while a word is pending
    step(0, 1, 7000001);
    step(1, 1, 4123456);
    step(1, 0, 0);
    for (int i = 0; i < 40; i++) step(i % 3 != 0, 0, 0);

    // odd fraction, irregular ticks
    step(0, 1, 5550037);
    for (int i = 0; i < 400; i++) step(i % 2 == 0, 0, 0);

    // reset mid-run
    rst_ni = 0;
    m_act = 0; m_shadow = 0; m_acc = 0; m_ratio = 0; m_carry = 0; m_pend = 0;
    @(negedge clk_i);
    compare("R1 reset mid-run");
    rst_ni = 1;
    step(1, 0, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule